// File: doc/BRIEF.md
# Advanced Load Address Table

This block remembers loads that were hoisted above stores, so that a later check can confirm that no store wrote the bytes those loads read. An advanced load allocates an entry holding its destination register, its start address and its access size. Every store is compared against all live entries, and each entry whose byte range shares at least one byte with the store is dropped. A check names a register and answers hit when that register's entry is still live. A hit means the speculation was safe; a miss means the recovery code must run.

Plain advanced loads and loads that are both control and data speculative allocate through the same load port. Branch-style checks and reload-style checks both use the same check port. The table is set associative. The set is taken from the low bits of the register number, and each set has `NUM_WAYS` ways. A flush input empties the whole table in one cycle. `NUM_SETS` and `NUM_WAYS` must be powers of two, at least 2.

Top module: `alat_table`

## Requirements
- R1: A load on `ld_valid` makes its register present: a later check of that register hits, provided no overlapping store or flush happens in between.
- R2: A check presented on `chk_valid` is answered at the next rising edge. At that edge `chk_done` is 1 and `chk_hit` carries the result. In a cycle with no check, both are 0 after the edge. A check does not change the table, so repeating it gives the same answer.
- R3: The access size code gives the byte count: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. A store on `st_valid` removes every live entry whose range [addr, addr+bytes) shares at least one byte with the store's range.
- R4: A store whose range only touches an entry's range at an edge, with no byte in common, leaves that entry live.
- R5: A load whose register already has an entry in its set overwrites that entry, so the old address is no longer tracked.
- R6: The set is the register number modulo `NUM_SETS`. A load with no entry for its register takes the lowest-numbered empty way. When no way is empty, the load evicts the way named by that set's round-robin pointer. The pointer starts at 0, advances by one only on an eviction, and wraps after the last way. A check on an evicted register misses. Emptiness and matching use the table as it stood before the edge.
- R7: A check in the same cycle as a store that removes the checked entry reports a miss.
- R8: `flush` empties every entry and resets all pointers in one cycle. A check in the flush cycle misses.
- R9: A load in the same cycle as `flush` is discarded. A load in the same cycle as a store is written after the store's removals, so it survives. A check does not see a load made in the same cycle.
- R10: After reset the table is empty, every check misses, and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the whole table |
| ld_valid | input | 1 | Advanced load allocates an entry |
| ld_reg | input | REG_W | Destination register of the load |
| ld_addr | input | ADDR_W | Start byte address of the load |
| ld_size | input | 2 | Load size code (0 to 3 gives 1 to 8 bytes) |
| st_valid | input | 1 | A store or other memory write is being snooped |
| st_addr | input | ADDR_W | Start byte address of the store |
| st_size | input | 2 | Store size code |
| chk_valid | input | 1 | Check request |
| chk_reg | input | REG_W | Register being checked |
| chk_done | output | 1 | A check result is present |
| chk_hit | output | 1 | Entry still present (1) or recovery needed (0) |

## Verification
Each check result appears one rising edge after the cycle that carries the check. Every load, store or flush takes effect at that same edge, so it is visible to a check issued in the following cycle. The bench drives each cycle's inputs at the falling edge and predicts both outputs from a behavioural model of the table as it stood before the edge. After the rising edge it advances the model, and it compares the outputs at the next falling edge, once per clock. Directed sequences cover byte-edge overlaps, replacement and eviction order, and same-cycle interactions. A seeded random phase follows them.

// File: rtl/alat_table.sv
module alat_table #(
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 2,
  parameter int REG_W    = 7,
  parameter int ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ld_valid,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  output logic              chk_done,
  output logic              chk_hit
);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int EXT_W = ADDR_W + 4;

  logic              valid_q [NUM_SETS][NUM_WAYS];
  logic [REG_W-1:0]  tag_q   [NUM_SETS][NUM_WAYS];
  logic [ADDR_W-1:0] addr_q  [NUM_SETS][NUM_WAYS];
  logic [1:0]        size_q  [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0]  rr_q    [NUM_SETS];
  logic              kill    [NUM_SETS][NUM_WAYS];
  logic [NUM_SETS-1:0] set_busy;

  function automatic logic overlaps(input logic [ADDR_W-1:0] a, input logic [1:0] asz,
                                    input logic [ADDR_W-1:0] b, input logic [1:0] bsz);
    logic [EXT_W-1:0] ae, be;
    ae = EXT_W'(a);
    be = EXT_W'(b);
    return (ae < be + (EXT_W'(1) << bsz)) && (be < ae + (EXT_W'(1) << asz));
  endfunction

  wire [SET_W-1:0] ld_set  = ld_reg[SET_W-1:0];
  wire [SET_W-1:0] chk_set = chk_reg[SET_W-1:0];

  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      set_busy[s] = 1'b0;
      for (int w = 0; w < NUM_WAYS; w++) begin
        kill[s][w] = valid_q[s][w] && st_valid &&
                     overlaps(addr_q[s][w], size_q[s][w], st_addr, st_size);
        set_busy[s] = set_busy[s] | valid_q[s][w];
      end
    end
  end

  logic             found, has_free, evict;
  logic [WAY_W-1:0] way_sel;

  always_comb begin
    found    = 1'b0;
    has_free = 1'b0;
    way_sel  = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (!found && valid_q[ld_set][w] && tag_q[ld_set][w] == ld_reg) begin
        found   = 1'b1;
        way_sel = WAY_W'(w);
      end
    if (!found)
      for (int w = NUM_WAYS - 1; w >= 0; w--)
        if (!valid_q[ld_set][w]) begin
          has_free = 1'b1;
          way_sel  = WAY_W'(w);
        end
    evict = !found && !has_free;
    if (evict) way_sel = rr_q[ld_set];
  end

  logic hit_now;
  always_comb begin
    hit_now = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (valid_q[chk_set][w] && !kill[chk_set][w] && tag_q[chk_set][w] == chk_reg)
        hit_now = 1'b1;
    hit_now = hit_now && chk_valid && !flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_done <= 1'b0;
      chk_hit  <= 1'b0;
      for (int s = 0; s < NUM_SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          tag_q[s][w]   <= '0;
          addr_q[s][w]  <= '0;
          size_q[s][w]  <= '0;
        end
      end
    end else begin
      chk_done <= chk_valid;
      chk_hit  <= hit_now;
      if (flush) begin
        for (int s = 0; s < NUM_SETS; s++) begin
          rr_q[s] <= '0;
          for (int w = 0; w < NUM_WAYS; w++) valid_q[s][w] <= 1'b0;
        end
      end else begin
        for (int s = 0; s < NUM_SETS; s++)
          for (int w = 0; w < NUM_WAYS; w++)
            if (kill[s][w]) valid_q[s][w] <= 1'b0;
        if (ld_valid) begin
          valid_q[ld_set][way_sel] <= 1'b1;
          tag_q[ld_set][way_sel]   <= ld_reg;
          addr_q[ld_set][way_sel]  <= ld_addr;
          size_q[ld_set][way_sel]  <= ld_size;
          if (evict) rr_q[ld_set] <= rr_q[ld_set] + 1'b1;
        end
      end
    end
  end

  assert_load_fills_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !flush |=> set_busy[$past(ld_set)]);

  assert_answer_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_done);

  assert_no_stray_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !chk_done && !chk_hit);

  assert_flush_check_misses_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush && chk_valid |=> chk_done && !chk_hit);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> set_busy == '0);
endmodule

// File: tb/alat_table_test.sv
`timescale 1ns/1ps
module alat_table_test;
  localparam int S = 4, W = 2, RW = 7, AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, ld_valid = 0, st_valid = 0, chk_valid = 0;
  logic [RW-1:0] ld_reg = 0, chk_reg = 0;
  logic [AW-1:0] ld_addr = 0, st_addr = 0;
  logic [1:0] ld_size = 0, st_size = 0;
  logic chk_done, chk_hit;

  always #2.5 clk = ~clk;

  alat_table #(.NUM_SETS(S), .NUM_WAYS(W), .REG_W(RW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr), .ld_size(ld_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_done(chk_done), .chk_hit(chk_hit));

  int checks = 0, errors = 0;
  bit mv [S][W];
  int mt [S][W], ma [S][W], ms [S][W], mrr [S];

  function automatic bit ovl(int a, int asz, int b, int bsz);
    return (a < b + (1 << bsz)) && (b < a + (1 << asz));
  endfunction

  task automatic model_clear();
    for (int s = 0; s < S; s++) begin
      mrr[s] = 0;
      for (int w = 0; w < W; w++) mv[s][w] = 0;
    end
  endtask

  task automatic step(input bit l, input int lr, input int la, input int lz,
                      input bit st, input int sa, input int sz,
                      input bit ck, input int cr, input bit fl, input string tag);
    bit exp_hit;
    bit snap [S][W];
    int ls, way;
    bit found;
    ld_valid = l; ld_reg = RW'(lr); ld_addr = AW'(la); ld_size = 2'(lz);
    st_valid = st; st_addr = AW'(sa); st_size = 2'(sz);
    chk_valid = ck; chk_reg = RW'(cr); flush = fl;
    exp_hit = 0;
    if (ck && !fl)
      for (int w = 0; w < W; w++) begin
        int cs = cr % S;
        if (mv[cs][w] && mt[cs][w] == cr && !(st && ovl(ma[cs][w], ms[cs][w], sa, sz)))
          exp_hit = 1;
      end
    @(posedge clk);
    if (fl) model_clear();
    else begin
      snap = mv;
      for (int s = 0; s < S; s++)
        for (int w = 0; w < W; w++)
          if (st && mv[s][w] && ovl(ma[s][w], ms[s][w], sa, sz)) mv[s][w] = 0;
      if (l) begin
        ls = lr % S; found = 0; way = -1;
        for (int w = 0; w < W; w++)
          if (!found && snap[ls][w] && mt[ls][w] == lr) begin found = 1; way = w; end
        if (!found)
          for (int w = 0; w < W; w++)
            if (way < 0 && !snap[ls][w]) way = w;
        if (way < 0) begin way = mrr[ls]; mrr[ls] = (mrr[ls] + 1) % W; end
        mv[ls][way] = 1; mt[ls][way] = lr; ma[ls][way] = la; ms[ls][way] = lz;
      end
    end
    @(negedge clk);
    checks++;
    if (chk_done !== ck || chk_hit !== exp_hit) begin
      errors++;
      $display("FAIL %s: done/hit actual %0b/%0b expected %0b/%0b", tag, chk_done, chk_hit, ck, exp_hit);
    end
    ld_valid = 0; st_valid = 0; chk_valid = 0; flush = 0;
  endtask

  task automatic ld(int r, int a, int z, string tag); step(1, r, a, z, 0, 0, 0, 0, 0, 0, tag); endtask
  task automatic sto(int a, int z, string tag); step(0, 0, 0, 0, 1, a, z, 0, 0, 0, tag); endtask
  task automatic chk(int r, string tag); step(0, 0, 0, 0, 0, 0, 0, 1, r, 0, tag); endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    checks++;
    if (chk_done !== 0 || chk_hit !== 0) begin
      errors++;
      $display("FAIL R10: done/hit actual %0b/%0b expected 0/0", chk_done, chk_hit);
    end
    rst_n = 1;
    @(negedge clk);
    chk(5, "R10");
    ld(5, 'h100, 3, "R1"); chk(5, "R1"); chk(5, "R2"); step(0,0,0,0,0,0,0,0,0,0, "R2");
    sto('h107, 0, "R3"); chk(5, "R3");
    ld(6, 'h200, 2, "R1");
    sto('h204, 2, "R4"); chk(6, "R4");
    sto('h1FE, 1, "R4"); chk(6, "R4");
    sto('h1FF, 1, "R3"); chk(6, "R3");
    ld(9, 'h300, 3, "R5"); ld(9, 'h400, 3, "R5");
    sto('h300, 3, "R5"); chk(9, "R5");
    ld(13, 'h500, 0, "R6"); ld(17, 'h600, 0, "R6");
    chk(9, "R6"); chk(13, "R6"); chk(17, "R6");
    ld(21, 'h700, 0, "R6"); chk(13, "R6"); chk(17, "R6"); chk(21, "R6");
    ld(2, 'h800, 2, "R7");
    step(0, 0, 0, 0, 1, 'h802, 0, 1, 2, 0, "R7"); chk(2, "R7");
    ld(10, 'h900, 2, "R7");
    step(0, 0, 0, 0, 1, 'h904, 0, 1, 10, 0, "R7");
    step(1, 14, 'hA00, 1, 1, 'hA00, 1, 1, 14, 0, "R9"); chk(14, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 1, 10, 1, "R8");
    chk(10, "R8"); chk(14, "R8"); chk(17, "R8");
    step(1, 3, 'hB00, 0, 0, 0, 0, 0, 0, 1, "R9"); chk(3, "R9");
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 19);
      step(op < 8, $urandom_range(0, 11), 'h100 + $urandom_range(0, 40), $urandom_range(0, 3),
           op >= 5 && op < 10, 'h100 + $urandom_range(0, 40), $urandom_range(0, 3),
           op % 2 == 0 || op > 12, $urandom_range(0, 11), op == 19, "R6");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule